// File: doc/BRIEF.md
# Integer-N synthesizer detector core

This block is the digital heart of an integer-N frequency synthesizer. All of its logic runs on one fast sampling clock. It detects rising edges on two slow clock inputs, one from the VCO side and one from the crystal. It divides the VCO-side clock by a programmable ratio N and the crystal clock by a programmable ratio R. The terminal count of each divider is the falling edge of that divided signal. A phase-frequency detector compares the two falling edges and drives two charge-pump enables. `up` sources current when the VCO edge is early. `dn` sinks current when it is late.

The detector has no dead zone. A phase error of one sampling cycle gives one cycle of single-sided drive. When both enables are active, they stay high together for a programmable anti-backlash time and then clear on the same edge. A lock detector watches the width of the single-sided drive in each comparison and raises a flag after a run of tight comparisons. The 4-bit charge-pump current code (0 to 15 steps of 75 µA) is registered and passed through unchanged.

Top module: `pfd_synth_core`

## Requirements
- R1: A VCO comparison event occurs on every N-th detected rising edge of `vco_in`, for any N from 240 to 65535. `up` rises one cycle after each such event, so successive `up` rising edges are N input periods apart.
- R2: A reference comparison event occurs on every R-th detected rising edge of `ref_in`, for any R from 2 to 1023. `dn` rises one cycle after each such event.
- R3: When the VCO event leads the reference event by k sampling cycles, `up` is high alone for exactly k cycles before `dn` joins it. When the reference event leads by k cycles, `dn` is high alone for k cycles.
- R4: There is no dead zone. Events that coincide produce no single-sided cycles, and a one-cycle offset produces exactly one.
- R5: Once `up` and `dn` are both high, they stay high together for `abl_sel`+1 cycles (`abl_sel` from 0 to 3) and then fall on the same clock edge.
- R6: `icp_out` equals `icp_code` delayed by one clock.
- R7: `locked` rises on the edge that ends the 16th consecutive comparison whose single-sided width is at most 2 cycles. It stays low after 15 such comparisons.
- R8: `locked` falls on the clock edge that ends the third single-sided cycle of a comparison.
- R9: A new N or R takes effect only from that divider's next terminal count. The period already in progress completes with the old ratio.
- R10: While `rst` is high at a clock edge, `up`, `dn`, `locked` and `icp_out` are cleared and both dividers restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| vco_in | input | 1 | VCO-side clock, sampled |
| ref_in | input | 1 | Crystal reference clock, sampled |
| n_ratio | input | 16 | Feedback divide ratio N |
| r_ratio | input | 10 | Reference divide ratio R |
| abl_sel | input | 2 | Anti-backlash extra cycles |
| icp_code | input | 4 | Charge-pump current code |
| up | output | 1 | Source enable |
| dn | output | 1 | Sink enable |
| icp_out | output | 4 | Registered current code |
| locked | output | 1 | Lock flag |

## Verification
The assertions assume that both slow clocks hold each level for at least one sampling cycle. They also assume the ratios stay within their legal ranges and that `abl_sel` changes only during reset. The stimulus builds both clocks from one cycle counter: the VCO clock has a two-cycle period and the reference clock has an even period with a programmed offset. The ratios are chosen so that both comparison periods match, and the phase error in sampling cycles is then a closed-form value. `abl_sel` is set only while reset is held, and ratios change only as whole values between comparisons.

// File: rtl/pfd_synth_core.sv
module pfd_synth_core #(
  parameter int NW       = 16,
  parameter int RW       = 10,
  parameter int ASW      = 2,
  parameter int CW       = 4,
  parameter int LOCK_RUN = 16,
  parameter int LOCK_TOL = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vco_in,
  input  logic          ref_in,
  input  logic [NW-1:0] n_ratio,
  input  logic [RW-1:0] r_ratio,
  input  logic [ASW-1:0] abl_sel,
  input  logic [CW-1:0] icp_code,
  output logic          up,
  output logic          dn,
  output logic [CW-1:0] icp_out,
  output logic          locked
);

  localparam int GW = $clog2(LOCK_RUN + 1);
  localparam int XW = $clog2(LOCK_TOL + 2);
  localparam logic [GW-1:0] RUN_LAST = GW'(LOCK_RUN - 1);
  localparam logic [XW-1:0] TOL_V    = XW'(LOCK_TOL);

  // input sampling: [0] newest, [1] previous
  logic [1:0] vs, rs;
  always_ff @(posedge clk) begin
    if (rst) begin
      vs <= '0;
      rs <= '0;
    end else begin
      vs <= {vs[0], vco_in};
      rs <= {rs[0], ref_in};
    end
  end

  wire v_edge = vs[0] & ~vs[1];
  wire r_edge = rs[0] & ~rs[1];

  // dividers: terminal count is the falling edge of the divided clock
  logic [NW-1:0] n_cnt, n_act;
  logic [RW-1:0] r_cnt, r_act;

  wire fv_evt = v_edge && (n_cnt == n_act - NW'(1));
  wire fr_evt = r_edge && (r_cnt == r_act - RW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      n_cnt <= '0;
      n_act <= n_ratio;
    end else if (v_edge) begin
      if (fv_evt) begin
        n_cnt <= '0;
        n_act <= n_ratio;
      end else begin
        n_cnt <= n_cnt + NW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_cnt <= '0;
      r_act <= r_ratio;
    end else if (r_edge) begin
      if (fr_evt) begin
        r_cnt <= '0;
        r_act <= r_ratio;
      end else begin
        r_cnt <= r_cnt + RW'(1);
      end
    end
  end

  // detector with anti-backlash hold
  logic [ASW-1:0] abl_cnt;
  wire both = up & dn;
  wire clr  = both && (abl_cnt == abl_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      up      <= 1'b0;
      dn      <= 1'b0;
      abl_cnt <= '0;
    end else begin
      up      <= fv_evt | (up & ~clr);
      dn      <= fr_evt | (dn & ~clr);
      abl_cnt <= (both && !clr) ? abl_cnt + ASW'(1) : '0;
    end
  end

  // lock detector
  logic [XW-1:0] xw;
  logic [GW-1:0] good;
  wire excl = up ^ dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      xw     <= '0;
      good   <= '0;
      locked <= 1'b0;
    end else begin
      if (clr)
        xw <= '0;
      else if (excl && xw <= TOL_V)
        xw <= xw + XW'(1);

      if (excl && xw >= TOL_V) begin
        locked <= 1'b0;
        good   <= '0;
      end else if (clr && xw <= TOL_V) begin
        if (good == RUN_LAST)
          locked <= 1'b1;
        else
          good <= good + GW'(1);
      end else if (clr) begin
        good <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) icp_out <= '0;
    else     icp_out <= icp_code;
  end

  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (rst)
    n_ratio >= NW'(240) && r_ratio >= RW'(2)); // R1
  AST_FV_SETS_UP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fv_evt)) |-> up); // R3
  AST_CLR_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(up) |-> (!dn || $past(fr_evt))); // R5
  AST_ABL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |-> abl_cnt <= abl_sel); // R5
  AST_ICP_PASS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> icp_out == $past(icp_code)); // R6
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(clr)); // R7
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(up ^ dn) || $past(rst))); // R8

endmodule

// File: tb/pfd_synth_core_tb.sv
module pfd_synth_core_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vco_in = 1'b0, ref_in = 1'b0;
  logic [15:0] n_ratio = 16'd240;
  logic [9:0]  r_ratio = 10'd120;
  logic [1:0]  abl_sel = 2'd0;
  logic [3:0]  icp_code = 4'd0;
  logic        up, dn, locked;
  logic [3:0]  icp_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_synth_core u_dut (
    .clk(clk), .rst(rst), .vco_in(vco_in), .ref_in(ref_in),
    .n_ratio(n_ratio), .r_ratio(r_ratio), .abl_sel(abl_sel),
    .icp_code(icp_code), .up(up), .dn(dn), .icp_out(icp_out),
    .locked(locked)
  );

  int n_chk = 0, n_fail = 0;
  int t, c_pr, c_d, c_dv;
  int ex_up[0:63], ex_dn[0:63], ov[0:63], lk[0:63], urise[0:63], drise[0:63];
  int ncmp, nur, ndr, acc_u, acc_d, acc_o, run;
  bit p_up, p_dn, got3, got4;
  int lk3, lk4;
  bit timed_out = 0;

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (up && !p_up) begin if (nur < 64) urise[nur] = t; nur++; end
    if (dn && !p_dn) begin if (ndr < 64) drise[ndr] = t; ndr++; end
    if (up ^ dn) begin
      run++;
      if (up) acc_u++; else acc_d++;
    end else run = 0;
    if (run == 3 && !got3) begin got3 = 1; lk3 = locked; end
    if (run == 4 && !got4) begin got4 = 1; lk4 = locked; end
    if (up && dn) acc_o++;
    if (p_up && p_dn && !up && !dn) begin
      if (ncmp < 64) begin
        ex_up[ncmp] = acc_u; ex_dn[ncmp] = acc_d; ov[ncmp] = acc_o; lk[ncmp] = locked;
      end
      ncmp++;
      acc_u = 0; acc_d = 0; acc_o = 0;
    end
    p_up = up; p_dn = dn;
    vco_in = (t >= c_dv) && ((t - c_dv) % 2 == 1);
    ref_in = (t >= c_d) && ((t - c_d) % c_pr >= c_pr / 2);
    t++;
  endtask

  task automatic start_cfg(input int pr, input int r, input int n,
                           input int d, input int dv, input int abl);
    @(negedge clk);
    rst = 1'b1; vco_in = 0; ref_in = 0;
    icp_code = 4'hA;
    c_pr = pr; c_d = d; c_dv = dv;
    r_ratio = 10'(r); n_ratio = 16'(n); abl_sel = 2'(abl);
    repeat (3) @(negedge clk);
    check_eq("R10 up in reset", int'(up), 0);
    check_eq("R10 dn in reset", int'(dn), 0);
    check_eq("R10 locked in reset", int'(locked), 0);
    check_eq("R10 icp_out in reset", int'(icp_out), 0);
    rst = 1'b0;
    t = 0; ncmp = 0; nur = 0; ndr = 0; acc_u = 0; acc_d = 0; acc_o = 0; run = 0;
    p_up = 0; p_dn = 0; got3 = 0; got4 = 0; lk3 = -1; lk4 = -1;
  endtask

  task automatic run_until(input int target, input int n);
    int lim;
    lim = t + (target - ncmp + 2) * 2 * n + 400;
    while (ncmp < target && t < lim) step();
    if (ncmp < target) begin
      n_chk++; n_fail++; timed_out = 1;
      $display("FAIL watchdog comparisons actual=%0d expected=%0d", ncmp, target);
    end
  endtask

  // phase = reference event time minus VCO event time, in sampling cycles
  function automatic int phase_of(input int pr, input int d, input int dv);
    return d - dv + 1 - pr / 2;
  endfunction

  task automatic check_shape(input int ph, input int abl, input int from, input int upto);
    for (int m = from; m < upto; m++) begin
      check_eq((ph > 0) ? "R3 up-only width" : ((ph == 0) ? "R4 zero error up-only" : "R3 up-only width"),
               ex_up[m], (ph > 0) ? ph : 0);
      check_eq((ph >= -1 && ph <= 1) ? "R4 dn-only width small error" : "R3 dn-only width",
               ex_dn[m], (ph < 0) ? -ph : 0);
      check_eq("R5 overlap cycles", ov[m], abl + 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog global timeout actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R6: current code sweep
    start_cfg(4, 120, 240, 1, 0, 0);
    for (int c = 0; c < 16; c++) begin
      icp_code = 4'(c);
      @(negedge clk);
      check_eq("R6 icp passthrough", int'(icp_out), c);
    end

    // R3 R4 R5: phase and anti-backlash sweep
    for (int ph = -4; ph <= 4; ph++) begin
      for (int abl = 0; abl < 4; abl++) begin
        int d, dv;
        d  = (ph >= -1) ? ph + 1 : 0;
        dv = (ph >= -1) ? 0 : -1 - ph;
        start_cfg(4, 120, 240, d, dv, abl);
        run_until(3, 240);
        if (!timed_out) begin
          check_shape(phase_of(4, d, dv), abl, 0, 3);
          check_eq("R1 up interval", urise[2] - urise[1], 480);
        end
      end
    end

    // R7: lock with error of +2 and -2 cycles
    for (int s = 0; s < 2; s++) begin
      int d, dv;
      d  = (s == 0) ? 3 : 0;
      dv = (s == 0) ? 0 : 1;
      start_cfg(4, 120, 240, d, dv, 1);
      run_until(17, 240);
      if (!timed_out) begin
        check_shape(phase_of(4, d, dv), 1, 0, 17);
        check_eq("R7 not locked after 15", lk[14], 0);
        check_eq("R7 locked after 16", lk[15], 1);
        check_eq("R7 stays locked", lk[16], 1);
      end
    end

    // R8: three-cycle error never locks
    start_cfg(4, 120, 240, 4, 0, 2);
    run_until(17, 240);
    if (!timed_out) begin
      check_eq("R8 up-only width 3", ex_up[16], 3);
      for (int m = 0; m < 17; m++) check_eq("R8 no lock at 3 cycles", lk[m], 0);
    end

    // R9 R8: ratio change after lock
    start_cfg(4, 120, 240, 1, 0, 1);
    run_until(17, 240);
    check_eq("R7 locked before change", lk[16], 1);
    n_ratio = 16'd242;
    got3 = 0; got4 = 0;
    run_until(19, 242);
    if (!timed_out) begin
      check_eq("R9 old period completes", urise[17] - urise[16], 480);
      check_eq("R9 new period applied", urise[18] - urise[17], 484);
      check_eq("R9 no error in pending period", ex_dn[17], 0);
      check_eq("R9 lock kept through pending period", lk[17], 1);
      check_eq("R3 late VCO dn-only width", ex_dn[18], 4);
      check_eq("R8 still locked after 2 cycles", lk3, 1);
      check_eq("R8 lock dropped after 3rd cycle", lk4, 0);
    end

    // R2: largest reference ratio
    start_cfg(2, 1023, 1023, 0, 0, 0);
    run_until(3, 1023);
    if (!timed_out) begin
      check_eq("R2 dn interval R=1023", drise[2] - drise[1], 2046);
      check_eq("R1 up interval N=1023", urise[2] - urise[1], 2046);
      check_shape(0, 0, 0, 3);
    end

    // R2: smallest reference ratio
    start_cfg(240, 2, 240, 119, 0, 3);
    run_until(3, 240);
    if (!timed_out) begin
      check_eq("R2 dn interval R=2", drise[2] - drise[1], 480);
      check_shape(0, 3, 0, 3);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule